// File: doc/BRIEF.md
# CAN Status and Interrupt Register

This block is the status-reporting part of a CAN controller. The protocol engine sends it single-cycle event strobes and level signals. The strobes report bus errors of a given type, frames received or sent without error, and each run of eleven recessive bits seen during bus-off recovery. The levels report the warning, passive and bus-off error states and the two error counts. From these the block keeps a 3-bit last-error code, two sticky success flags and registered copies of the error-state levels. It also holds a read-only view of the error counters.

A small CPU register bus reads and writes four 16-bit words: control, status, error counters and interrupt identifier. Two enable bits in the control word decide which events raise a sticky status interrupt. The pending interrupt drives a level output and appears as 0x8000 in the identifier word. Reading the status word acknowledges it. The CPU can write last-error code 7, which the bus never produces. That code stays in place until the next hardware event, so software can tell whether anything happened on the bus since the write.

Top module: `can_stat_top`

## Requirements
- R1: After synchronous reset every register, `bus_rdata` and `irq_o` read 0.
- R2: An error strobe whose code is 1 to 6 loads that code into the status word bits 2..0 (6 = received CRC mismatch, 5 = dominant driven but recessive sampled). A strobe carrying code 0 or 7 leaves the code unchanged.
- R3: A receive-ok strobe sets status bit 4 and a transmit-ok strobe sets status bit 3. Either one clears the code to 0.
- R4: A recovery strobe (eleven recessive bits seen during bus-off recovery) loads code 5. When several hardware sources arrive in one cycle, the priority is error strobe first, then recovery, then success.
- R5: A CPU write to the status word (offset 1) loads bits 2..0. A written 7 holds until a hardware event replaces it. When a hardware code update and a CPU write fall in the same cycle, the hardware value is kept.
- R6: Status bits 4 and 3 stay set until the CPU writes 0 to them. A hardware set in the same cycle as the write wins.
- R7: With control bit 1 set, a receive-ok strobe, a transmit-ok strobe or any hardware code update sets the pending interrupt.
- R8: With control bit 0 set, any change of the warning level (status bit 6) or the bus-off level (status bit 7) sets the pending interrupt.
- R9: A change of the passive level (status bit 5) never sets the pending interrupt, and no CPU write does either.
- R10: `irq_o` is high exactly while the interrupt is pending. The identifier word (offset 3) reads 0x8000 while it is pending and 0 otherwise.
- R11: A read of the status word clears the pending interrupt. A qualifying event in the same cycle keeps it set.
- R12: The counter word (offset 2) reads the passive flag in bit 15, the receive count in bits 14..8 and the transmit count in bits 7..0. CPU writes to it have no effect.
- R13: Read data appears on `bus_rdata` one cycle after `bus_rd`, taken from the register values before that clock edge. It is 0 in cycles without a read. The control word (offset 0) reads back what was written to bits 1..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| err_stb | input | 1 | Bus error detected |
| err_code | input | 3 | Error type for err_stb |
| recov_stb | input | 1 | Eleven recessive bits seen during bus-off recovery |
| rx_ok_stb | input | 1 | Frame received without error |
| tx_ok_stb | input | 1 | Frame sent without error |
| ewarn_in | input | 1 | Warning level |
| epass_in | input | 1 | Error-passive level |
| boff_in | input | 1 | Bus-off level |
| rp_in | input | 1 | Receive-passive flag |
| rec_in | input | REC_W | Receive error count |
| tec_in | input | TEC_W | Transmit error count |
| irq_o | output | 1 | Status interrupt pending |

## Verification
The error strobe is driven with every code, including the reserved 0 and 7. This shows whether the code field filters its inputs or simply loads whatever arrives. Strobes are also stacked in one cycle, and strobes are placed in the same cycle as CPU writes and status reads. These cases separate the fixed source priority and the hardware-wins rule from a last-writer order. The interrupt is tried with each enable alone and with passive-level changes and CPU writes that must stay silent. This tells the status-change path apart from the error path and from spurious sources. A behavioural model compared on every clock catches any cycle in which pending state, read data or latency drift.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;
  localparam int LEC_W = 3;

  typedef enum logic [LEC_W-1:0] {
    LEC_NONE  = 3'd0,
    LEC_STUFF = 3'd1,
    LEC_FORM  = 3'd2,
    LEC_ACK   = 3'd3,
    LEC_BIT1  = 3'd4,
    LEC_BIT0  = 3'd5,
    LEC_CRC   = 3'd6,
    LEC_MARK  = 3'd7
  } lec_e;

  localparam int OFS_CTRL  = 0;
  localparam int OFS_STAT  = 1;
  localparam int OFS_ECNT  = 2;
  localparam int OFS_INTID = 3;

  localparam int ST_TXOK  = 3;
  localparam int ST_RXOK  = 4;
  localparam int ST_EPASS = 5;
  localparam int ST_EWARN = 6;
  localparam int ST_BOFF  = 7;

  localparam int CT_EIE = 0;
  localparam int CT_SIE = 1;

  localparam logic [15:0] INTID_STATUS = 16'h8000;
endpackage

// File: rtl/can_lec_unit.sv
module can_lec_unit
  import can_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             err_stb,
  input  logic [LEC_W-1:0] err_code,
  input  logic             recov_stb,
  input  logic             ok_stb,
  input  logic             cpu_wr,
  input  logic [LEC_W-1:0] cpu_code,
  output logic [LEC_W-1:0] lec_q,
  output logic             hw_upd
);
  logic             err_valid;
  logic [LEC_W-1:0] lec_d;

  assign err_valid = err_stb && (err_code != LEC_NONE) && (err_code != LEC_MARK);
  assign hw_upd    = err_valid || recov_stb || ok_stb;

  always_comb begin
    lec_d = lec_q;
    if (err_valid)      lec_d = err_code;
    else if (recov_stb) lec_d = LEC_BIT0;
    else if (ok_stb)    lec_d = LEC_NONE;
    else if (cpu_wr)    lec_d = cpu_code;
  end

  always_ff @(posedge clk) begin
    if (rst) lec_q <= LEC_NONE;
    else     lec_q <= lec_d;
  end

  p_err_load_r2: assert property (@(posedge clk) disable iff (rst)
    err_valid |=> lec_q == $past(err_code));
  p_bad_code_r2: assert property (@(posedge clk) disable iff (rst)
    (err_stb && !err_valid && !recov_stb && !ok_stb && !cpu_wr) |=> $stable(lec_q));
  p_recov_r4: assert property (@(posedge clk) disable iff (rst)
    (recov_stb && !err_valid) |=> lec_q == LEC_BIT0);
  p_ok_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (ok_stb && !err_valid && !recov_stb) |=> lec_q == LEC_NONE);
  p_mark_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (lec_q == LEC_MARK && !hw_upd && !cpu_wr) |=> lec_q == LEC_MARK);
endmodule

// File: rtl/can_ok_flags.sv
module can_ok_flags #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_stb,
  input  logic             cpu_wr,
  input  logic [NFLAG-1:0] cpu_val,
  output logic [NFLAG-1:0] flag_q
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flag_q[i] <= 1'b0;
      else if (set_stb[i]) flag_q[i] <= 1'b1;
      else if (cpu_wr)     flag_q[i] <= cpu_val[i];
    end

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && !cpu_wr) |=> flag_q[i]);
    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
      set_stb[i] |=> flag_q[i]);
  end
endmodule

// File: rtl/can_err_state.sv
module can_err_state #(
  parameter int REC_W = 7,
  parameter int TEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ewarn_in,
  input  logic             epass_in,
  input  logic             boff_in,
  input  logic             rp_in,
  input  logic [REC_W-1:0] rec_in,
  input  logic [TEC_W-1:0] tec_in,
  output logic             ewarn_q,
  output logic             epass_q,
  output logic             boff_q,
  output logic             rp_q,
  output logic [REC_W-1:0] rec_q,
  output logic [TEC_W-1:0] tec_q,
  output logic             err_chg
);
  assign err_chg = (ewarn_in != ewarn_q) || (boff_in != boff_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ewarn_q <= 1'b0;
      epass_q <= 1'b0;
      boff_q  <= 1'b0;
      rp_q    <= 1'b0;
      rec_q   <= '0;
      tec_q   <= '0;
    end else begin
      ewarn_q <= ewarn_in;
      epass_q <= epass_in;
      boff_q  <= boff_in;
      rp_q    <= rp_in;
      rec_q   <= rec_in;
      tec_q   <= tec_in;
    end
  end

  p_chg_seen_r8: assert property (@(posedge clk) disable iff (rst)
    err_chg |=> (ewarn_q != $past(ewarn_q)) || (boff_q != $past(boff_q)));
endmodule

// File: rtl/can_irq_pend.sv
module can_irq_pend (
  input  logic clk,
  input  logic rst,
  input  logic sie,
  input  logic eie,
  input  logic sc_evt,
  input  logic er_evt,
  input  logic stat_rd,
  output logic pend_q
);
  logic set_now;

  assign set_now = (sie && sc_evt) || (eie && er_evt);

  always_ff @(posedge clk) begin
    if (rst)          pend_q <= 1'b0;
    else if (set_now) pend_q <= 1'b1;
    else if (stat_rd) pend_q <= 1'b0;
  end

  p_sc_set_r7: assert property (@(posedge clk) disable iff (rst)
    (sie && sc_evt) |=> pend_q);
  p_er_set_r8: assert property (@(posedge clk) disable iff (rst)
    (eie && er_evt) |=> pend_q);
  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!pend_q && !(sie && sc_evt) && !(eie && er_evt)) |=> !pend_q);
  p_ack_r11: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !set_now) |=> !pend_q);
endmodule

// File: rtl/can_stat_top.sv
module can_stat_top
  import can_stat_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16,
  parameter int REC_W  = 7,
  parameter int TEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              err_stb,
  input  logic [LEC_W-1:0]  err_code,
  input  logic              recov_stb,
  input  logic              rx_ok_stb,
  input  logic              tx_ok_stb,
  input  logic              ewarn_in,
  input  logic              epass_in,
  input  logic              boff_in,
  input  logic              rp_in,
  input  logic [REC_W-1:0]  rec_in,
  input  logic [TEC_W-1:0]  tec_in,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_ECNT  = ADDR_W'(OFS_ECNT);
  localparam logic [ADDR_W-1:0] A_INTID = ADDR_W'(OFS_INTID);
  localparam int ECNT_W = 1 + REC_W + TEC_W;

  logic             wr_ctrl, wr_stat, rd_stat;
  logic             sie_q, eie_q;
  logic [LEC_W-1:0] lec_q;
  logic             lec_hw;
  logic [1:0]       ok_q;
  logic             ewarn_q, epass_q, boff_q, rp_q, err_chg;
  logic [REC_W-1:0] rec_q;
  logic [TEC_W-1:0] tec_q;
  logic             pend_q;
  logic [DATA_W-1:0] rd_val;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign rd_stat = bus_rd && (bus_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      sie_q <= 1'b0;
      eie_q <= 1'b0;
    end else if (wr_ctrl) begin
      sie_q <= bus_wdata[CT_SIE];
      eie_q <= bus_wdata[CT_EIE];
    end
  end

  can_lec_unit u_lec (
    .clk       (clk),
    .rst       (rst),
    .err_stb   (err_stb),
    .err_code  (err_code),
    .recov_stb (recov_stb),
    .ok_stb    (rx_ok_stb || tx_ok_stb),
    .cpu_wr    (wr_stat),
    .cpu_code  (bus_wdata[LEC_W-1:0]),
    .lec_q     (lec_q),
    .hw_upd    (lec_hw)
  );

  can_ok_flags #(.NFLAG(2)) u_ok (
    .clk     (clk),
    .rst     (rst),
    .set_stb ({rx_ok_stb, tx_ok_stb}),
    .cpu_wr  (wr_stat),
    .cpu_val ({bus_wdata[ST_RXOK], bus_wdata[ST_TXOK]}),
    .flag_q  (ok_q)
  );

  can_err_state #(.REC_W(REC_W), .TEC_W(TEC_W)) u_est (
    .clk      (clk),
    .rst      (rst),
    .ewarn_in (ewarn_in),
    .epass_in (epass_in),
    .boff_in  (boff_in),
    .rp_in    (rp_in),
    .rec_in   (rec_in),
    .tec_in   (tec_in),
    .ewarn_q  (ewarn_q),
    .epass_q  (epass_q),
    .boff_q   (boff_q),
    .rp_q     (rp_q),
    .rec_q    (rec_q),
    .tec_q    (tec_q),
    .err_chg  (err_chg)
  );

  can_irq_pend u_irq (
    .clk     (clk),
    .rst     (rst),
    .sie     (sie_q),
    .eie     (eie_q),
    .sc_evt  (lec_hw || rx_ok_stb || tx_ok_stb),
    .er_evt  (err_chg),
    .stat_rd (rd_stat),
    .pend_q  (pend_q)
  );

  assign irq_o = pend_q;

  always_comb begin
    rd_val = '0;
    unique case (bus_addr)
      A_CTRL: begin
        rd_val[CT_SIE] = sie_q;
        rd_val[CT_EIE] = eie_q;
      end
      A_STAT: begin
        rd_val[LEC_W-1:0] = lec_q;
        rd_val[ST_TXOK]   = ok_q[0];
        rd_val[ST_RXOK]   = ok_q[1];
        rd_val[ST_EPASS]  = epass_q;
        rd_val[ST_EWARN]  = ewarn_q;
        rd_val[ST_BOFF]   = boff_q;
      end
      A_ECNT:  rd_val = DATA_W'({rp_q, rec_q, tec_q});
      A_INTID: rd_val = pend_q ? DATA_W'(INTID_STATUS) : '0;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end

  p_idle_zero_r13: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);
  p_intid_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_INTID) |=>
      bus_rdata == ($past(irq_o) ? DATA_W'(INTID_STATUS) : DATA_W'(0)));
  p_ecnt_ro_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_ECNT) |=>
      bus_rdata[TEC_W-1:0] == $past(tec_q) && bus_rdata[ECNT_W-1] == $past(rp_q));
  p_cpu_silent_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !irq_o && !err_stb && !recov_stb && !rx_ok_stb && !tx_ok_stb && !err_chg)
      |=> !irq_o);
endmodule

// File: tb/can_stat_top_test.sv
module can_stat_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        err_stb = 1'b0;
  logic [2:0]  err_code = '0;
  logic        recov_stb = 1'b0, rx_ok_stb = 1'b0, tx_ok_stb = 1'b0;
  logic        ewarn_in = 1'b0, epass_in = 1'b0, boff_in = 1'b0, rp_in = 1'b0;
  logic [6:0]  rec_in = '0;
  logic [7:0]  tec_in = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  can_stat_top uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_stb(err_stb), .err_code(err_code),
    .recov_stb(recov_stb), .rx_ok_stb(rx_ok_stb), .tx_ok_stb(tx_ok_stb),
    .ewarn_in(ewarn_in), .epass_in(epass_in), .boff_in(boff_in), .rp_in(rp_in),
    .rec_in(rec_in), .tec_in(tec_in), .irq_o(irq_o)
  );

  // behavioural reference model
  int m_lec, m_rx, m_tx, m_ew, m_ep, m_bo, m_rp, m_rec, m_tec, m_sie, m_eie, m_pend, m_rd;

  always @(posedge clk) begin
    int rv, hw, sc, er, hit;
    if (rst) begin
      m_lec = 0; m_rx = 0; m_tx = 0; m_ew = 0; m_ep = 0; m_bo = 0; m_rp = 0;
      m_rec = 0; m_tec = 0; m_sie = 0; m_eie = 0; m_pend = 0; m_rd = 0;
    end else begin
      case (bus_addr)
        2'd0: rv = m_sie * 2 + m_eie;
        2'd1: rv = m_lec + 8 * m_tx + 16 * m_rx + 32 * m_ep + 64 * m_ew + 128 * m_bo;
        2'd2: rv = m_rp * 32768 + m_rec * 256 + m_tec;
        default: rv = m_pend ? 32768 : 0;
      endcase
      m_rd = bus_rd ? rv : 0;
      hw = 1;
      if (err_stb && err_code >= 1 && err_code <= 6) m_lec = err_code;
      else if (recov_stb) m_lec = 5;
      else if (rx_ok_stb || tx_ok_stb) m_lec = 0;
      else begin
        hw = 0;
        if (bus_wr && bus_addr == 2'd1) m_lec = bus_wdata[2:0];
      end
      if (rx_ok_stb) m_rx = 1; else if (bus_wr && bus_addr == 2'd1) m_rx = bus_wdata[4];
      if (tx_ok_stb) m_tx = 1; else if (bus_wr && bus_addr == 2'd1) m_tx = bus_wdata[3];
      sc = hw;
      er = (ewarn_in != m_ew) || (boff_in != m_bo);
      hit = (m_sie && sc) || (m_eie && er);
      if (hit) m_pend = 1;
      else if (bus_rd && bus_addr == 2'd1) m_pend = 0;
      if (bus_wr && bus_addr == 2'd0) begin m_sie = bus_wdata[1]; m_eie = bus_wdata[0]; end
      m_ew = ewarn_in; m_ep = epass_in; m_bo = boff_in;
      m_rp = rp_in; m_rec = rec_in; m_tec = tec_in;
    end
  end

  task automatic check(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(int'(irq_o), m_pend, {phase, " irq model"});
      check(int'(bus_rdata), m_rd, {phase, " rdata model"});
    end
  end

  task automatic wr(input int a, input int d);
    bus_addr = a[1:0]; bus_wdata = d[15:0]; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string req);
    bus_addr = a[1:0]; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(int'(bus_rdata), exp, req);
  endtask

  task automatic err_pulse(input int code);
    err_stb = 1'b1; err_code = code[2:0];
    @(negedge clk);
    err_stb = 1'b0;
  endtask

  task automatic ok_pulse(input bit rx, input bit tx);
    rx_ok_stb = rx; tx_ok_stb = tx;
    @(negedge clk);
    rx_ok_stb = 1'b0; tx_ok_stb = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    phase = "R1";
    check(int'(irq_o), 0, "R1 irq after reset");
    rd(1, 16'h0000, "R1 status after reset");
    rd(2, 16'h0000, "R1 counters after reset");
    rd(3, 16'h0000, "R1 intid after reset");

    phase = "R2";
    err_pulse(6); rd(1, 16'h0006, "R2 crc code");
    err_pulse(2); rd(1, 16'h0002, "R2 form code");
    err_pulse(7); rd(1, 16'h0002, "R2 code 7 ignored");
    err_pulse(0); rd(1, 16'h0002, "R2 code 0 ignored");

    phase = "R3";
    ok_pulse(1, 0); rd(1, 16'h0010, "R3 rx ok");
    ok_pulse(0, 1); rd(1, 16'h0018, "R3 tx ok");

    phase = "R4";
    recov_stb = 1'b1; @(negedge clk); recov_stb = 1'b0;
    rd(1, 16'h001D, "R4 recovery code 5");
    err_stb = 1'b1; err_code = 3'd1; recov_stb = 1'b1; rx_ok_stb = 1'b1;
    @(negedge clk);
    err_stb = 1'b0; recov_stb = 1'b0; rx_ok_stb = 1'b0;
    rd(1, 16'h0019, "R4 error beats recovery and success");

    phase = "R5";
    wr(1, 16'h0007); rd(1, 16'h0007, "R5 marker written");
    repeat (3) @(negedge clk);
    rd(1, 16'h0007, "R5 marker held");
    err_stb = 1'b1; err_code = 3'd3; bus_addr = 2'd1; bus_wdata = 16'h0007; bus_wr = 1'b1;
    @(negedge clk);
    err_stb = 1'b0; bus_wr = 1'b0;
    rd(1, 16'h0003, "R5 hardware wins over write");

    phase = "R6";
    ok_pulse(1, 0); repeat (2) @(negedge clk);
    rd(1, 16'h0010, "R6 rx ok sticky");
    wr(1, 16'h0010); rd(1, 16'h0010, "R6 write 1 keeps");
    wr(1, 16'h0000); rd(1, 16'h0000, "R6 write 0 clears");

    phase = "R7";
    wr(0, 16'h0002); rd(0, 16'h0002, "R13 control readback");
    check(int'(irq_o), 0, "R7 no irq yet");
    ok_pulse(0, 1);
    check(int'(irq_o), 1, "R7 tx ok raises irq");
    phase = "R10";
    rd(3, 16'h8000, "R10 intid pending");
    phase = "R11";
    rd(1, 16'h0008, "R11 status read value");
    check(int'(irq_o), 0, "R11 read clears irq");
    rd(3, 16'h0000, "R10 intid idle");
    bus_addr = 2'd1; bus_rd = 1'b1; rx_ok_stb = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; rx_ok_stb = 1'b0;
    check(int'(irq_o), 1, "R11 event beats read clear");
    rd(1, 16'h0018, "R11 clearing read");
    check(int'(irq_o), 0, "R11 cleared");

    phase = "R9";
    wr(1, 16'h0007);
    check(int'(irq_o), 0, "R9 cpu write silent");
    epass_in = 1'b1; repeat (2) @(negedge clk);
    check(int'(irq_o), 0, "R9 epass silent");
    rd(1, 16'h0027, "R9 status with passive");

    phase = "R8";
    wr(0, 16'h0001);
    ok_pulse(1, 0);
    check(int'(irq_o), 0, "R7 disabled status change");
    ewarn_in = 1'b1; @(negedge clk);
    check(int'(irq_o), 1, "R8 warning raises irq");
    rd(1, 16'h0070, "R8 status read");
    check(int'(irq_o), 0, "R8 cleared");
    boff_in = 1'b1; @(negedge clk);
    check(int'(irq_o), 1, "R8 bus-off raises irq");
    rd(1, 16'h00F0, "R8 status read 2");

    phase = "R12";
    rp_in = 1'b1; rec_in = 7'h55; tec_in = 8'hA3;
    @(negedge clk);
    rd(2, 16'hD5A3, "R12 counter layout");
    wr(2, 16'hFFFF); rd(2, 16'hD5A3, "R12 write ignored");

    phase = "R13";
    repeat (2) @(negedge clk);
    check(int'(bus_rdata), 0, "R13 idle rdata");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL R13 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule